// File: doc/BRIEF.md
# Sigma-Delta Converter Serial Conversion Controller

This block is the device-side digital sequencer for a two-wire converter port made of one host-driven clock line and one device-driven data line. While idle, both lines rest high. The host pulls the clock line low to wake the block. On that edge the block latches a two-bit channel address and starts a conversion. A cycle counter stands in for the modulator's conversion clock and sets how long the conversion lasts.

Early in a conversion the host may add extra falling clock edges. Each one trims one bit of resolution, from 16 down to a floor of 10, and halves the conversion time. The single data line carries three kinds of information. It is a busy flag while the conversion runs, an acknowledge pulse for each accepted trim edge, and the serial output that shifts the result out afterwards. The filtered result comes in on a parallel port and is sampled when the conversion ends, so the modulator and decimator sit outside this block. Before it reaches the controller, the clock line passes through a synchronizer and a glitch filter that needs several cycles of agreement.

Top module: `sdadc_serial_ctrl`

## Requirements
- R1: After reset, sdat_out is 1, conv_busy is 0 and res_bits is 16.
- R2: A filtered falling edge of sclk_in while idle raises conv_busy and latches addr_in onto chan_sel (0 to 3 select channels one to four). Later changes of addr_in leave chan_sel unchanged until the next start. While sclk_in stays low after the start edge, sdat_out stays 1. It drops to 0 once sclk_in rises.
- R3: Each accepted trim edge lowers res_bits by one, to a floor of 10. Further trim edges change nothing and get no acknowledge.
- R4: A falling edge counts as a trim edge only while fewer than 2^WIN_LOG (512) cycles have passed since the conversion began. Later falling edges during the conversion are ignored.
- R5: After an accepted trim edge, sdat_out is 1 until sclk_in rises or the trim window closes, whichever comes first. It is 0 at all other times while converting.
- R6: conv_busy stays high for exactly 2^m clock cycles, where m is the final resolution. When it falls, sdat_out goes to 1.
- R7: After completion, each falling edge of sclk_in puts the next result bit on sdat_out. The m bits come from the top of sample_in as sampled at completion, bit 15 (sign) first and then downward, m bits in all.
- R8: A sample of 0x8000 is replaced by 0x8001 before it is shifted out.
- R9: After the m-th read edge, the next rise of sclk_in returns sdat_out to 1 and the block to idle, ready for a new start edge.
- R10: Low pulses on sclk_in shorter than AGREE_CYCLES clock cycles, after synchronization, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Host serial clock line, idle high |
| addr_in | input | 2 | Channel address, latched on the start edge |
| sample_in | input | 16 | Two's-complement result from the decimator |
| sdat_out | output | 1 | Data line: busy, acknowledge and serial result |
| chan_sel | output | 2 | Latched channel select for the input multiplexer |
| conv_busy | output | 1 | High while a conversion is running |
| res_bits | output | 5 | Current resolution in bits (10 to 16) |

## Verification
An edge on sclk_in reaches the control state after two synchronizer stages, four agreement cycles and one state register, about seven cycles in all. The bench therefore holds every clock level for 20 cycles and samples sdat_out, chan_sel and res_bits at the end of that time, well after the response is due and before the next edge. The conversion length is measured exactly: a monitor counts the clock cycles during which conv_busy is high and compares the count with 2^m. The window tests place their edges about 100 cycles away from the 512-cycle boundary, so the seven-cycle filter delay cannot move an edge across it.

// File: rtl/sdadc_pkg.sv
package sdadc_pkg;

    // Control sequencer states
    typedef enum logic [1:0] {
        ST_SLEEP = 2'd0,
        ST_CONV  = 2'd1,
        ST_READ  = 2'd2
    } conv_state_e;

    // Single-cycle pulses produced by the clock-line filter
    typedef struct packed {
        logic fall;
        logic rise;
    } line_edge_t;

endpackage

// File: rtl/sdadc_clk_filter.sv
module sdadc_clk_filter
    import sdadc_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int AGREE_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_in,
    output line_edge_t edge_o
);

    localparam int AGR_W = (AGREE_CYCLES < 2) ? 1 : $clog2(AGREE_CYCLES + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [AGR_W-1:0]       agree;
        logic                   level;
        logic                   fall;
        logic                   rise;
    } filt_t;

    filt_t q, d;
    logic  synced;
    logic  settled;

    assign synced = q.sync[SYNC_STAGES-1];

    // The parameter picks whether an agreement count is kept at all
    generate
        if (AGREE_CYCLES < 2) begin : g_no_agree
            assign settled = 1'b1;
        end else begin : g_agree
            assign settled = (q.agree == AGR_W'(AGREE_CYCLES - 1));
        end
    endgenerate

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC_STAGES-2:0], line_in};
        d.fall = 1'b0;
        d.rise = 1'b0;
        if (synced != q.level) begin
            if (settled) begin
                d.level = synced;
                d.fall  = ~synced;
                d.rise  = synced;
                d.agree = '0;
            end else begin
                d.agree = q.agree + 1'b1;
            end
        end else begin
            d.agree = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync  <= '1;
            q.agree <= '0;
            q.level <= 1'b1;
            q.fall  <= 1'b0;
            q.rise  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign edge_o.fall = q.fall;
    assign edge_o.rise = q.rise;

endmodule

// File: rtl/sdadc_conv_timer.sv
module sdadc_conv_timer #(
    parameter int MAX_RES = 16,
    parameter int WIN_LOG = 9,
    parameter int RES_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [RES_W-1:0] res,
    output logic             win_open,
    output logic             win_last,
    output logic             done
);

    localparam int CNT_W = MAX_RES;
    localparam int WIN   = 1 << WIN_LOG;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] end_mask;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // Last count of a 2^res-cycle conversion
    assign end_mask = {CNT_W{1'b1}} >> (RES_W'(MAX_RES) - res);
    assign win_open = (cnt_q < CNT_W'(WIN));
    assign win_last = (cnt_q == CNT_W'(WIN - 1));
    assign done     = (cnt_q == end_mask);

endmodule

// File: rtl/sdadc_serial_ctrl.sv
module sdadc_serial_ctrl
    import sdadc_pkg::*;
#(
    parameter int MAX_RES      = 16,
    parameter int MIN_RES      = 10,
    parameter int WIN_LOG      = 9,
    parameter int ADDR_W       = 2,
    parameter int SYNC_STAGES  = 2,
    parameter int AGREE_CYCLES = 4,
    localparam int RES_W       = $clog2(MAX_RES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_in,
    input  logic [ADDR_W-1:0]  addr_in,
    input  logic [MAX_RES-1:0] sample_in,
    output logic               sdat_out,
    output logic [ADDR_W-1:0]  chan_sel,
    output logic               conv_busy,
    output logic [RES_W-1:0]   res_bits
);

    localparam logic [MAX_RES-1:0] MOST_NEG = {1'b1, {(MAX_RES-1){1'b0}}};

    typedef struct packed {
        conv_state_e        state;
        logic [ADDR_W-1:0]  chan;
        logic [RES_W-1:0]   res;
        logic               ack;
        logic [MAX_RES-1:0] shreg;
        logic [RES_W-1:0]   left;
        logic               dout;
    } ctrl_t;

    ctrl_t              q, d;
    line_edge_t         sclk_edge;
    logic               sclk_fall;
    logic               sclk_rise;
    logic               win_open;
    logic               win_last;
    logic               conv_done;
    logic               timer_clear;
    logic               timer_run;
    logic [MAX_RES-1:0] sample_fix;

    sdadc_clk_filter #(
        .SYNC_STAGES  (SYNC_STAGES),
        .AGREE_CYCLES (AGREE_CYCLES)
    ) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (sclk_in),
        .edge_o  (sclk_edge)
    );

    assign sclk_fall = sclk_edge.fall;
    assign sclk_rise = sclk_edge.rise;

    sdadc_conv_timer #(
        .MAX_RES (MAX_RES),
        .WIN_LOG (WIN_LOG),
        .RES_W   (RES_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (timer_clear),
        .run      (timer_run),
        .res      (q.res),
        .win_open (win_open),
        .win_last (win_last),
        .done     (conv_done)
    );

    // Symmetric range: the most negative code is never sent
    assign sample_fix = (sample_in == MOST_NEG) ? (MOST_NEG | MAX_RES'(1)) : sample_in;
    assign timer_run  = (q.state == ST_CONV);

    always_comb begin
        d           = q;
        timer_clear = 1'b0;
        unique case (q.state)
            ST_SLEEP: begin
                if (sclk_fall) begin
                    d.state     = ST_CONV;
                    d.chan      = addr_in;
                    d.res       = RES_W'(MAX_RES);
                    d.ack       = 1'b1;
                    timer_clear = 1'b1;
                end
            end
            ST_CONV: begin
                if (sclk_rise) begin
                    d.ack = 1'b0;
                end
                if (sclk_fall && win_open && (q.res > RES_W'(MIN_RES))) begin
                    d.res = q.res - 1'b1;
                    d.ack = 1'b1;
                end
                if (win_last) begin
                    d.ack = 1'b0;
                end
                if (conv_done) begin
                    d.state = ST_READ;
                    d.ack   = 1'b0;
                    d.shreg = sample_fix;
                    d.left  = q.res;
                    d.dout  = 1'b1;
                end
            end
            ST_READ: begin
                if (sclk_fall && (q.left != '0)) begin
                    d.dout  = q.shreg[MAX_RES-1];
                    d.shreg = {q.shreg[MAX_RES-2:0], 1'b0};
                    d.left  = q.left - 1'b1;
                end else if (sclk_rise && (q.left == '0)) begin
                    d.state = ST_SLEEP;
                    d.dout  = 1'b1;
                end
            end
            default: begin
                d.state = ST_SLEEP;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_SLEEP;
            q.chan  <= '0;
            q.res   <= RES_W'(MAX_RES);
            q.ack   <= 1'b0;
            q.shreg <= '0;
            q.left  <= '0;
            q.dout  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (q.state)
            ST_CONV: sdat_out = q.ack;
            ST_READ: sdat_out = q.dout;
            default: sdat_out = 1'b1;
        endcase
    end

    assign conv_busy = (q.state == ST_CONV);
    assign chan_sel  = q.chan;
    assign res_bits  = q.res;

endmodule

// File: rtl/sdadc_ctrl_checker.sv
module sdadc_ctrl_checker #(
    parameter int MAX_RES = 16,
    parameter int MIN_RES = 10,
    parameter int ADDR_W  = 2,
    parameter int RES_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sdat_out,
    input logic              conv_busy,
    input logic [ADDR_W-1:0] chan_sel,
    input logic [RES_W-1:0]  res_bits,
    input logic              sclk_fall,
    input logic              win_open
);

    p_start_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_busy) |-> $past(sclk_fall));

    p_chan_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_busy && $past(conv_busy)) |-> $stable(chan_sel));

    p_res_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_bits >= RES_W'(MIN_RES)) && (res_bits <= RES_W'(MAX_RES)));

    p_res_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_busy && $past(conv_busy)) |->
            ((res_bits == $past(res_bits)) || (res_bits == $past(res_bits) - 1'b1)));

    p_res_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_busy && $past(conv_busy) && !$past(win_open)) |-> $stable(res_bits));

    p_ack_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_busy && !win_open) |-> !sdat_out);

    p_done_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_busy) |-> sdat_out);

endmodule

bind sdadc_serial_ctrl sdadc_ctrl_checker #(
    .MAX_RES (MAX_RES),
    .MIN_RES (MIN_RES),
    .ADDR_W  (ADDR_W),
    .RES_W   (RES_W)
) u_ctrl_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .sdat_out  (sdat_out),
    .conv_busy (conv_busy),
    .chan_sel  (chan_sel),
    .res_bits  (res_bits),
    .sclk_fall (sclk_fall),
    .win_open  (win_open)
);

// File: tb/sdadc_serial_ctrl_test.sv
`timescale 1ns/1ps
module sdadc_serial_ctrl_test;

    localparam int HALF = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_in = 1'b1;
    logic [1:0]  addr_in = 2'b00;
    logic [15:0] sample_in = 16'h0000;
    logic        sdat_out;
    logic [1:0]  chan_sel;
    logic        conv_busy;
    logic [4:0]  res_bits;

    int n_chk  = 0;
    int n_fail = 0;
    int run_len = 0;
    int busy_len = 0;
    logic busy_prev = 1'b0;

    always #2 clk = ~clk;

    sdadc_serial_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_in   (sclk_in),
        .addr_in   (addr_in),
        .sample_in (sample_in),
        .sdat_out  (sdat_out),
        .chan_sel  (chan_sel),
        .conv_busy (conv_busy),
        .res_bits  (res_bits)
    );

    // Length of the most recent busy interval, in clock cycles
    always @(negedge clk) begin
        if (conv_busy) begin
            run_len = run_len + 1;
        end else if (busy_prev) begin
            busy_len = run_len;
            run_len  = 0;
        end
        busy_prev = conv_busy;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Start edge, then the rise that ends the start pulse
    task automatic start_conv(input logic [1:0] addr);
        addr_in = addr;
        sclk_in = 1'b0;
        tick(HALF);
        chk(sdat_out == 1'b1, "R2 start ack", int'(sdat_out), 1);
        chk(conv_busy == 1'b1, "R2 busy", int'(conv_busy), 1);
        chk(chan_sel == addr, "R2 channel", int'(chan_sel), int'(addr));
        chk(res_bits == 5'd16, "R3 initial res", int'(res_bits), 16);
        sclk_in = 1'b1;
        tick(HALF);
        chk(sdat_out == 1'b0, "R2 busy low", int'(sdat_out), 0);
    endtask

    task automatic trim_pulse(input logic exp_ack, input int exp_res);
        sclk_in = 1'b0;
        tick(HALF);
        chk(sdat_out == exp_ack, "R5 ack level", int'(sdat_out), int'(exp_ack));
        chk(res_bits == 5'(exp_res), "R3 res step", int'(res_bits), exp_res);
        sclk_in = 1'b1;
        tick(HALF);
        chk(sdat_out == 1'b0, "R5 ack cleared by rise", int'(sdat_out), 0);
    endtask

    task automatic wait_done(input int m);
        while (conv_busy) tick(1);
        tick(2);
        chk(busy_len == (1 << m), "R6 duration", busy_len, 1 << m);
        chk(sdat_out == 1'b1, "R6 done high", int'(sdat_out), 1);
    endtask

    task automatic read_word(input int m, input logic [15:0] smp, input string tag);
        logic [15:0] expv;
        expv = (smp == 16'h8000) ? 16'h8001 : smp;
        for (int i = 0; i < m; i++) begin
            sclk_in = 1'b0;
            tick(HALF);
            chk(sdat_out == expv[15-i], tag, int'(sdat_out), int'(expv[15-i]));
            sclk_in = 1'b1;
            tick(HALF);
            if (i < m - 1) begin
                chk(sdat_out == expv[15-i], tag, int'(sdat_out), int'(expv[15-i]));
            end
        end
        chk(sdat_out == 1'b1, "R9 idle high", int'(sdat_out), 1);
        chk(conv_busy == 1'b0, "R9 idle", int'(conv_busy), 0);
    endtask

    task automatic t_reset;
        chk(sdat_out == 1'b1, "R1 sdat", int'(sdat_out), 1);
        chk(conv_busy == 1'b0, "R1 busy", int'(conv_busy), 0);
        chk(res_bits == 5'd16, "R1 res", int'(res_bits), 16);
    endtask

    task automatic t_glitch;
        sclk_in = 1'b0;
        tick(2);
        sclk_in = 1'b1;
        tick(HALF);
        chk(conv_busy == 1'b0, "R10 glitch busy", int'(conv_busy), 0);
        chk(sdat_out == 1'b1, "R10 glitch sdat", int'(sdat_out), 1);
    endtask

    // Ten bits, with two trim edges past the floor
    task automatic t_res10;
        sample_in = 16'hE5A7;
        start_conv(2'b11);
        for (int k = 1; k <= 8; k++) begin
            trim_pulse(k <= 6, (k <= 6) ? 16 - k : 10);
        end
        addr_in = 2'b00;
        tick(HALF);
        chk(chan_sel == 2'b11, "R2 channel held", int'(chan_sel), 3);
        wait_done(10);
        chk(res_bits == 5'd10, "R3 floor", int'(res_bits), 10);
        read_word(10, sample_in, "R7 data 10b");
    endtask

    task automatic t_res12;
        sample_in = 16'h1234;
        start_conv(2'b10);
        for (int k = 1; k <= 4; k++) begin
            trim_pulse(1'b1, 16 - k);
        end
        wait_done(12);
        read_word(12, sample_in, "R7 data 12b");
    endtask

    // Trim edge near the window end, held low across the close, then a late edge
    task automatic t_window;
        sample_in = 16'h6C93;
        start_conv(2'b00);
        tick(340);
        sclk_in = 1'b0;
        tick(HALF);
        chk(sdat_out == 1'b1, "R5 ack before close", int'(sdat_out), 1);
        chk(res_bits == 5'd15, "R3 one trim", int'(res_bits), 15);
        tick(150);
        chk(sdat_out == 1'b0, "R5 window close clears ack", int'(sdat_out), 0);
        sclk_in = 1'b1;
        tick(HALF);
        sclk_in = 1'b0;
        tick(HALF);
        chk(sdat_out == 1'b0, "R4 late edge no ack", int'(sdat_out), 0);
        chk(res_bits == 5'd15, "R4 late edge ignored", int'(res_bits), 15);
        sclk_in = 1'b1;
        tick(HALF);
        wait_done(15);
        read_word(15, sample_in, "R7 data 15b");
    endtask

    task automatic t_clamp16;
        sample_in = 16'h8000;
        start_conv(2'b01);
        addr_in = 2'b10;
        tick(HALF);
        chk(chan_sel == 2'b01, "R2 channel held", int'(chan_sel), 1);
        wait_done(16);
        read_word(16, sample_in, "R8 clamp");
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(3);
        t_reset();
        t_glitch();
        t_res10();
        t_res12();
        t_window();
        t_clamp16();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule